// File: doc/BRIEF.md
# Dual-Speed Synchronized Clock Divider

This block derives three related clocks from one base reference. The processor clock is high for one third of its period and the auxiliary clock is square. Both run at one third of the base rate in fast mode, or at 1/768 of it in slow mode. The peripheral clock is square and always runs at one sixth of the base rate. The logic is clocked by a reference at twice the base rate (`clk_ref`), so one base cycle is two reference cycles. This lets the 1.5-base-cycle high time of the square clock come straight out of flops.

The speed request is a level input. It is synchronised and then debounced asymmetrically: it must sit low for 195 base cycles before slow mode is recognised, and high for 6 base cycles before fast mode is recognised. A recognised change is applied only on a transition of the peripheral clock. Each phase of the divide-by-3 sequencer is stretched or shortened as a whole, so no output pulse is ever cut short. An external alignment input clears every counter and forces all three clocks high. A freeze request from the stop controller holds every counter and every output. Single-cycle strobes mark each rising and falling edge of the processor clock, for use by neighbouring control logic.

Top module: `ckd_clkgen`

## Requirements
- R1: While `rst_n` is low at a `clk_ref` edge, `clk_o`, `clk50_o` and `pclk_o` are 1 after that edge, both strobes are 0, and the block is in fast mode.
- R2: In fast mode, `clk_o` has a period of 6 `clk_ref` cycles and is high for 2 of them. `clk50_o` has the same period, is high for 3 cycles, and is high whenever `clk_o` is high. After reset or alignment release, output k (k counted from 0) gives `clk_o`=1 for k mod 6 in {0,1} and `clk50_o`=1 for k mod 6 in {5,0,1}.
- R3: `clk_o` and `clk50_o` always fall on the same `clk_ref` edge, in both speeds.
- R4: `pclk_o` has a period of 12 `clk_ref` cycles with 6 high and 6 low, in either speed. After reset or alignment release it is high for k mod 12 in {8..11,0,1}, so in fast mode its falling edge coincides with a falling edge of `clk_o`.
- R5: In slow mode, each divide-by-3 phase lasts `PRE_DIV` (256) `clk_ref` cycles. The `clk_o` period is 1536 cycles with 512 high, and `clk50_o` is high for 768.
- R6: Slow mode is recognised only after the synchronised `slofst_i` has been low (0 = slow) for 390 consecutive `clk_ref` cycles. A low pulse one cycle shorter leaves fast mode in place.
- R7: Fast mode is recognised only after the synchronised `slofst_i` has been high (1 = fast) for 12 consecutive `clk_ref` cycles. A high pulse one cycle shorter leaves slow mode in place.
- R8: The applied speed changes only on a `clk_ref` edge where `pclk_o` toggles. From fast to slow, the recognised request is applied within 6 cycles of recognition, and the next phase step follows 256 cycles later.
- R9: While `csync_i` is high, all three clocks are 1 from the following edge onward. On release, counting restarts from k = 0 as in R2 and R4. This takes priority over freeze.
- R10: While `freeze_i` is high (and `csync_i` low), the three clocks and the counters hold. Counting resumes from the held point on release.
- R11: `clk_rise_o` (`clk_fall_o`) is high for exactly the one cycle in which `clk_o` first shows 1 (0) after being 0 (1). The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock at twice the base rate |
| rst_n | input | 1 | Synchronous active-low reset |
| slofst_i | input | 1 | Speed request level, 1 = fast, 0 = slow (asynchronous) |
| csync_i | input | 1 | Alignment: clear counters and force clocks high |
| freeze_i | input | 1 | Freeze request from the stop controller |
| clk_o | output | 1 | One-third duty processor clock |
| clk50_o | output | 1 | Square auxiliary clock, falls with `clk_o` |
| pclk_o | output | 1 | Square peripheral clock at base/6 |
| clk_rise_o | output | 1 | One-cycle strobe on a `clk_o` rising edge |
| clk_fall_o | output | 1 | One-cycle strobe on a `clk_o` falling edge |

## Verification
Some properties are checked on every cycle by assertions. These are the shared falling edge of the two divide-by-3 clocks, the containment of `clk_o` inside `clk50_o`, forced-high alignment, holding under freeze, and strobe exclusivity. They also check that a speed change lands only on a peripheral-clock transition and that a recognition always follows a full debounce count. Other behaviour shows only in the bench scenarios. This covers the exact phase sequence after release, peripheral-clock alignment in fast mode, the slow-mode periods and widths, and the debounce boundaries at 389/390 and 11/12 cycles. It also covers how freeze and alignment interact at every phase offset.

// File: rtl/ckd_pkg.sv
// Shared types and phase decode for the dual-speed clock divider.
// Assumes the logic runs at twice the base rate, so one divide-by-3 step
// is one reference cycle in fast mode.
package ckd_pkg;

    typedef enum logic {
        SPD_SLOW = 1'b0,
        SPD_FAST = 1'b1
    } speed_e;

    localparam int REF_PER_BASE = 2;   // reference cycles per base cycle
    localparam int PH_STEPS     = 6;   // divide-by-3 in half base cycles
    localparam int PC_STEPS     = 12;  // divide-by-6 in half base cycles
    localparam int PH_W         = $clog2(PH_STEPS);
    localparam int PC_W         = $clog2(PC_STEPS);

    // One-third duty clock: high on the first two steps.
    function automatic logic clk33_of(input logic [PH_W-1:0] ph);
        return ph < PH_W'(2);
    endfunction

    // Square clock: rises one step early, falls with the one-third clock.
    function automatic logic clk50_of(input logic [PH_W-1:0] ph);
        return (ph < PH_W'(2)) || (ph == PH_W'(PH_STEPS - 1));
    endfunction

    // Peripheral clock: falls with the one-third clock on a count of 2.
    function automatic logic pclk_of(input logic [PC_W-1:0] pc);
        return (pc < PC_W'(2)) || (pc >= PC_W'(8));
    endfunction

endpackage

// File: rtl/ckd_speed_filter.sv
// Speed request synchroniser, asymmetric debounce and edge-aligned apply.
// Assumes slofst_i is asynchronous; the hold counts are in base cycles and
// are converted to reference cycles here. The recognised speed is applied
// only when pclk_edge_i reports a peripheral-clock transition.
module ckd_speed_filter
    import ckd_pkg::*;
#(
    parameter int SLOW_HOLD   = 195,
    parameter int FAST_HOLD   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   slofst_i,
    input  logic   pclk_edge_i,
    output speed_e act_o
);
    localparam int SLOW_CYC = SLOW_HOLD * REF_PER_BASE;
    localparam int FAST_CYC = FAST_HOLD * REF_PER_BASE;
    localparam int MAX_CYC  = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CW       = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_CYC - 1);
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_CYC - 1);

    logic          sync_lvl;
    speed_e        rec_q;
    speed_e        act_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] limit;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            logic [SYNC_STAGES-1:0] sy_q;
            // Shift the raw request through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sy_q <= '1;
                else        sy_q <= {sy_q[SYNC_STAGES-2:0], slofst_i};
            end
            assign sync_lvl = sy_q[SYNC_STAGES-1];
        end else begin : g_single
            logic sy_q;
            // Single capture flop when one stage is configured.
            always_ff @(posedge clk) begin
                if (!rst_n) sy_q <= 1'b1;
                else        sy_q <= slofst_i;
            end
            assign sync_lvl = sy_q;
        end
    endgenerate

    // Leaving fast needs the long hold, leaving slow the short one.
    assign limit = (rec_q == SPD_FAST) ? SLOW_LIM : FAST_LIM;

    // Count consecutive disagreeing samples; recognise at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= SPD_FAST;
            run_q <= '0;
        end else if (speed_e'(sync_lvl) == rec_q) begin
            run_q <= '0;
        end else if (run_q == limit) begin
            rec_q <= speed_e'(sync_lvl);
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // Apply the recognised speed only on a peripheral-clock transition.
    always_ff @(posedge clk) begin
        if (!rst_n)           act_q <= SPD_FAST;
        else if (pclk_edge_i) act_q <= rec_q;
    end

    assign act_o = act_q;

    a_r8_apply_on_pclk_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> $past(pclk_edge_i));

    a_r6_slow_after_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rec_q) == SPD_FAST && rec_q == SPD_SLOW) |-> ($past(run_q) == SLOW_LIM));

    a_r7_fast_after_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rec_q) == SPD_SLOW && rec_q == SPD_FAST) |-> ($past(run_q) == FAST_LIM));

endmodule

// File: rtl/ckd_prescaler.sv
// Step generator for the divide-by-3 sequencer. Fast: a step every cycle.
// Slow: a step every PRE_DIV cycles. The count is held at zero while fast
// or aligned, so the first slow step comes a full PRE_DIV after the switch.
module ckd_prescaler
    import ckd_pkg::*;
#(
    parameter int PRE_DIV = 256
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr_i,
    input  logic   run_i,
    input  speed_e speed_i,
    output logic   tick_o
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] cnt_q;
    logic          wrap;

    assign wrap   = (cnt_q == LAST);
    assign tick_o = run_i && ((speed_i == SPD_FAST) || wrap);

    // Advance the slow-mode prescale count while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || speed_i == SPD_FAST) cnt_q <= '0;
        else if (run_i)                              cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/ckd_phase_gen.sv
// Divide-by-3 sequencer producing the one-third and square clocks plus
// edge strobes. Assumes tick_i is the step enable; sync_i forces step 0,
// which decodes to both clocks high.
module ckd_phase_gen
    import ckd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic tick_i,
    output logic clk33_o,
    output logic clk50_o,
    output logic rise_o,
    output logic fall_o
);
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_nxt;
    logic            c33_q, c50_q, rise_q, fall_q;
    logic            c33_nxt;

    // Next step: cleared by alignment, advanced by the step enable.
    always_comb begin
        if (sync_i)      ph_nxt = '0;
        else if (tick_i) ph_nxt = (ph_q == PH_W'(PH_STEPS - 1)) ? '0 : ph_q + 1'b1;
        else             ph_nxt = ph_q;
        c33_nxt = clk33_of(ph_nxt);
    end

    // Register the step, both decoded clocks and the edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            c33_q  <= 1'b1;
            c50_q  <= 1'b1;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            ph_q   <= ph_nxt;
            c33_q  <= c33_nxt;
            c50_q  <= clk50_of(ph_nxt);
            rise_q <= c33_nxt && !c33_q;
            fall_q <= !c33_nxt && c33_q;
        end
    end

    assign clk33_o = c33_q;
    assign clk50_o = c50_q;
    assign rise_o  = rise_q;
    assign fall_o  = fall_q;

    a_r3_shared_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c33_q) |-> $fell(c50_q));

    a_r3_square_falls_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c50_q) |-> $fell(c33_q));

    a_r11_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (c33_q && !$past(c33_q)));

    a_r11_fall_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q |-> (!c33_q && $past(c33_q)));

endmodule

// File: rtl/ckd_pclk_gen.sv
// Peripheral clock divider at one sixth of the base rate, independent of
// speed. Reports in edge_o whether its output toggles at the coming edge,
// which is when a speed change may be applied.
module ckd_pclk_gen
    import ckd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic run_i,
    output logic pclk_o,
    output logic edge_o
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;
    logic            pclk_q;
    logic            pclk_nxt;

    // Next count: cleared by alignment, held by freeze.
    always_comb begin
        if (sync_i)     pc_nxt = '0;
        else if (run_i) pc_nxt = (pc_q == PC_W'(PC_STEPS - 1)) ? '0 : pc_q + 1'b1;
        else            pc_nxt = pc_q;
        pclk_nxt = pclk_of(pc_nxt);
    end

    assign edge_o = (pclk_nxt != pclk_q);

    // Register the count and the decoded peripheral clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            pclk_q <= 1'b1;
        end else begin
            pc_q   <= pc_nxt;
            pclk_q <= pclk_nxt;
        end
    end

    assign pclk_o = pclk_q;

    a_r10_pclk_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && !run_i) |=> $stable(pclk_q));

endmodule

// File: rtl/ckd_clkgen.sv
// Top of the dual-speed clock divider. Combines the speed filter, prescaler,
// divide-by-3 sequencer and peripheral divider. Assumes clk_ref runs at
// twice the base rate; alignment overrides freeze, and reset overrides both.
module ckd_clkgen
    import ckd_pkg::*;
#(
    parameter int PRE_DIV     = 256,
    parameter int SLOW_HOLD   = 195,
    parameter int FAST_HOLD   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic slofst_i,
    input  logic csync_i,
    input  logic freeze_i,
    output logic clk_o,
    output logic clk50_o,
    output logic pclk_o,
    output logic clk_rise_o,
    output logic clk_fall_o
);
    speed_e speed;
    logic   run;
    logic   tick;
    logic   pclk_edge;

    assign run = !csync_i && !freeze_i;

    ckd_speed_filter #(
        .SLOW_HOLD  (SLOW_HOLD),
        .FAST_HOLD  (FAST_HOLD),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_filter (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .slofst_i   (slofst_i),
        .pclk_edge_i(pclk_edge),
        .act_o      (speed)
    );

    ckd_prescaler #(
        .PRE_DIV(PRE_DIV)
    ) u_pre (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .clr_i  (csync_i),
        .run_i  (run),
        .speed_i(speed),
        .tick_o (tick)
    );

    ckd_phase_gen u_phase (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .sync_i (csync_i),
        .tick_i (tick),
        .clk33_o(clk_o),
        .clk50_o(clk50_o),
        .rise_o (clk_rise_o),
        .fall_o (clk_fall_o)
    );

    ckd_pclk_gen u_pclk (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .sync_i(csync_i),
        .run_i (!freeze_i),
        .pclk_o(pclk_o),
        .edge_o(pclk_edge)
    );

    a_r9_align_forces_high: assert property (@(posedge clk_ref) disable iff (!rst_n)
        csync_i |=> (clk_o && clk50_o && pclk_o));

    a_r10_freeze_holds: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (freeze_i && !csync_i) |=> ($stable(clk_o) && $stable(clk50_o) && $stable(pclk_o)));

    a_r11_strobes_exclusive: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $onehot0({clk_rise_o, clk_fall_o}));

    a_r2_clk_within_square: assert property (@(posedge clk_ref) disable iff (!rst_n)
        clk_o |-> clk50_o);

endmodule

// File: tb/sim_ckd_clkgen.sv
// Bench: per-cycle arithmetic model for fast-mode sweeps over freeze and
// alignment offsets; edge timing measurement for the slow-mode and
// debounce-boundary scenarios.
module sim_ckd_clkgen;

    logic clk_ref = 1'b0;
    logic rst_n   = 1'b0;
    logic slofst  = 1'b1;
    logic csync   = 1'b0;
    logic freeze  = 1'b0;
    logic clk_o, clk50_o, pclk_o, clk_rise_o, clk_fall_o;

    int   n_chk = 0;
    int   n_err = 0;
    int   ncyc  = 0;
    logic prev_clk, prev_c50, prev_pclk;

    int   mk = 0;
    logic m_clk = 1'b1, m_rise = 1'b0, m_fall = 1'b0;

    always #2 clk_ref = ~clk_ref;

    ckd_clkgen u0 (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .slofst_i  (slofst),
        .csync_i   (csync),
        .freeze_i  (freeze),
        .clk_o     (clk_o),
        .clk50_o   (clk50_o),
        .pclk_o    (pclk_o),
        .clk_rise_o(clk_rise_o),
        .clk_fall_o(clk_fall_o)
    );

    task automatic check_int(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        prev_clk  = clk_o;
        prev_c50  = clk50_o;
        prev_pclk = pclk_o;
        @(negedge clk_ref);
        ncyc++;
    endtask

    // One modelled cycle: update the model at the edge, compare after it.
    task automatic step(input string req);
        logic nclk;
        logic [4:0] act, exp;
        prev_clk  = clk_o;
        prev_c50  = clk50_o;
        prev_pclk = pclk_o;
        @(posedge clk_ref);
        if (!rst_n) begin
            mk = 0; m_clk = 1'b1; m_rise = 1'b0; m_fall = 1'b0;
        end else begin
            if (csync)        mk = 0;
            else if (!freeze) mk = (mk + 1) % 12;
            nclk   = (mk % 6) < 2;
            m_rise = nclk && !m_clk;
            m_fall = !nclk && m_clk;
            m_clk  = nclk;
        end
        @(negedge clk_ref);
        ncyc++;
        exp = {m_clk, ((mk % 6) < 2) || ((mk % 6) == 5),
               ((mk % 12) < 2) || ((mk % 12) >= 8), m_rise, m_fall};
        act = {clk_o, clk50_o, pclk_o, clk_rise_o, clk_fall_o};
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s cycle %0d {clk,clk50,pclk,rise,fall} actual %b expected %b",
                     req, ncyc, act, exp);
        end
    endtask

    task automatic run_model(input int n, input string req);
        for (int i = 0; i < n; i++) step(req);
    endtask

    task automatic count_edges(input int n, output int e);
        e = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (clk_o != prev_clk) e++;
        end
    endtask

    // sel: 0 = clk_o, 1 = clk50_o, 2 = pclk_o
    task automatic wait_edge(input int sel, input logic lvl, input string req, output int t);
        logic cur, prv;
        t = -1;
        for (int i = 0; i < 4000; i++) begin
            tick();
            cur = (sel == 0) ? clk_o : (sel == 1) ? clk50_o : pclk_o;
            prv = (sel == 0) ? prev_clk : (sel == 1) ? prev_c50 : prev_pclk;
            if (cur == lvl && prv != lvl) begin
                t = ncyc;
                break;
            end
        end
        if (t < 0) begin
            n_chk++; n_err++;
            $display("FAIL %s edge timeout on output %0d actual none expected level %0d", req, sel, lvl);
        end
    endtask

    initial begin
        int e, r1, f1, r2, cr, cf, p1, p2, q1;
        @(negedge clk_ref);
        // R1: reset state
        run_model(4, "R1");
        rst_n = 1'b1;
        // R2 R3 R4 R11: fast sequence from release
        run_model(48, "R2 R3 R4 R11");
        // R10: freeze at every peripheral offset, lengths 1..3
        for (int off = 0; off < 12; off++) begin
            for (int len = 1; len <= 3; len++) begin
                run_model(off, "R2");
                freeze = 1'b1;
                run_model(len, "R10");
                freeze = 1'b0;
            end
        end
        // R9: alignment at every divide-by-3 offset
        for (int off = 0; off < 6; off++) begin
            run_model(off, "R2");
            csync = 1'b1;
            run_model(3, "R9");
            csync = 1'b0;
            run_model(14, "R4 R9");
        end
        // R9 over R10: alignment wins during freeze
        freeze = 1'b1; csync = 1'b1;
        run_model(2, "R9");
        csync = 1'b0;
        run_model(3, "R10");
        freeze = 1'b0;
        run_model(8, "R10");

        // R6: 389-cycle low pulse is ignored
        slofst = 1'b0;
        repeat (389) tick();
        slofst = 1'b1;
        count_edges(600, e);
        check_int("R6", "edges after 389-cycle low (>=150 means fast)", (e >= 150) ? 1 : 0, 1);

        // R6 R8: 390-cycle hold enters slow at a peripheral edge
        slofst = 1'b0;
        count_edges(380, e);
        count_edges(11, e);
        check_int("R6", "fast edges before recognition (>=2)", (e >= 2) ? 1 : 0, 1);
        count_edges(7, e);
        count_edges(240, e);
        check_int("R8", "edges in first slow phase", e, 0);

        // R5 R3 R4: slow-mode timing
        wait_edge(0, 1'b1, "R5", r1);
        wait_edge(0, 1'b0, "R5", f1);
        check_int("R3", "square clock fell with clk in slow", {prev_c50, clk50_o}, 2'b10);
        wait_edge(0, 1'b1, "R5", r2);
        check_int("R5", "slow clk period", r2 - r1, 1536);
        check_int("R5", "slow clk high", f1 - r1, 512);
        wait_edge(1, 1'b1, "R5", cr);
        wait_edge(1, 1'b0, "R5", cf);
        check_int("R5", "slow square high", cf - cr, 768);
        check_int("R3", "clk fell with square in slow", {prev_clk, clk_o}, 2'b10);
        wait_edge(2, 1'b1, "R4", p1);
        wait_edge(2, 1'b0, "R4", q1);
        wait_edge(2, 1'b1, "R4", p2);
        check_int("R4", "pclk period in slow", p2 - p1, 12);
        check_int("R4", "pclk high in slow", q1 - p1, 6);

        // R7: 11-cycle high pulse is ignored
        slofst = 1'b1;
        repeat (11) tick();
        slofst = 1'b0;
        count_edges(300, e);
        check_int("R7", "edges after 11-cycle high (<=2 means slow)", (e <= 2) ? 1 : 0, 1);

        // R7 R2: 12-cycle hold returns to fast
        slofst = 1'b1;
        repeat (12) tick();
        count_edges(40, e);
        check_int("R7", "edges after return to fast (>=8)", (e >= 8) ? 1 : 0, 1);
        wait_edge(0, 1'b1, "R2", r1);
        wait_edge(0, 1'b0, "R2", f1);
        wait_edge(0, 1'b1, "R2", r2);
        check_int("R2", "fast clk period", r2 - r1, 6);
        check_int("R2", "fast clk high", f1 - r1, 2);
        wait_edge(1, 1'b1, "R2", cr);
        wait_edge(1, 1'b0, "R2", cf);
        check_int("R2", "fast square high", cf - cr, 3);

        // R9 R4: realign and re-run the model
        csync = 1'b1;
        tick();
        mk = 0; m_clk = 1'b1;
        run_model(2, "R9");
        csync = 1'b0;
        run_model(30, "R4 R9");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_ref);
        n_chk++; n_err++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule